// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block is the controller-side engine that pushes one write burst into a double-data-rate SDRAM. It runs on a clock at twice the memory clock, so each of its cycles is one half of a memory clock and it can place strobe and data events on half-cycle boundaries. A host presents a bank, a starting column and a full burst of data with byte masks through a ready/valid handshake. The block then issues the WRITE command with that bank and column, opens the strobe with a low preamble, sends one data beat per half-cycle and closes the strobe with a low postamble before it releases the bus.

Two mode settings control each burst: a length code and a burst ordering, either sequential or interleaved. Both are captured when the request is accepted. The host supplies the data word for each column offset inside the aligned block. The block sends those words in the order the memory will store them. A separate activation notice starts a per-bank timer, and no write reaches a bank until that bank's programmable activate-to-write delay has passed.

Top module: `ddr_wr_burst`

## Requirements
- R1: In the two fast cycles that follow an accepting edge, `cmd_write` is 1 and `cmd_ba` and `cmd_addr` carry the accepted bank and column. `mem_ck` is 1 in the first of those cycles and 0 in the second. Outside the command slots, `cmd_write`, `cmd_ba` and `cmd_addr` are 0.
- R2: The burst length code maps as follows: 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and the reserved code 0 gives 2 beats. Code, ordering, column and data are captured at acceptance, so changes made afterwards do not alter the running burst.
- R3: The first data beat appears in slot 2, counting the first command cycle as slot 0. That is one memory clock after the command starts.
- R4: `dqs_oe` is 1 in slots 0 through N+2. `dqs` is 0 in slots 0 and 1, which form the preamble. From slot 2 through slot N+1, `dqs` is 1 in even slots and 0 in odd slots. `dqs` is 0 in slot N+2, the postamble.
- R5: `dq_oe` and `dm_oe` are 1 exactly in slots 2 through N+1, and beat i is driven in slot 2+i.
- R6: Let s be the column modulo N. Beat i carries the word and mask for column offset (s+i) mod N when `cfg_bt` is 0 (sequential), and for offset s XOR i when `cfg_bt` is 1 (interleaved). Word k occupies `req_data[k*DQ_W +: DQ_W]` and mask k occupies `req_mask[k*DQ_W/8 +: DQ_W/8]`.
- R7: When no burst is running, every output enable is 0 and `dqs`, `dq` and `dm` are 0.
- R8: `req_ready` stays 0 for a bank that has had no activation notice since reset. After `act_valid` is sampled for a bank, `req_ready` stays 0 for that bank for the next 2*`cfg_trcd` fast cycles.
- R9: `req_ready` is 1 only when the block is idle, the target bank's delay has elapsed and `mem_ck` is 0. A command therefore always starts on a rising memory clock.
- R10: `done` is 1 for exactly slot N+3, with every output enable 0. `req_ready` is 0 in that slot and can rise two cycles later.
- R11: After reset, `req_ready`, `cmd_write`, `done` and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl | input | 2 | Burst length code |
| cfg_bt | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_trcd | input | TRCD_W | Activate-to-write delay in memory clocks |
| act_valid | input | 1 | Notice that a bank was activated |
| act_bank | input | BA_W | Bank named by the activation notice |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Write request accepted on this edge when valid |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_data | input | 8*DQ_W | Data words indexed by column offset |
| req_mask | input | DQ_W | Byte masks indexed by column offset |
| mem_ck | output | 1 | Memory clock phase |
| cmd_write | output | 1 | WRITE command slot |
| cmd_ba | output | BA_W | Bank address during the command |
| cmd_addr | output | COL_W | Column address during the command |
| dqs | output | 1 | Data strobe |
| dqs_oe | output | 1 | Strobe output enable |
| dq | output | DQ_W | Data beat |
| dq_oe | output | 1 | Data output enable |
| dm | output | DQ_W/8 | Byte mask beat |
| dm_oe | output | 1 | Mask output enable |
| done | output | 1 | Burst finished pulse |

## Verification
A wrong slot count or a wrong latched length shows up at once as a strobe edge or an enable edge in the wrong slot. It is visible within the same burst, at the latest in the postamble slot. A wrong ordering or a wrong captured word appears as a mismatched `dq` or `dm` value on the first beat whose offset differs. A faulty per-bank timer shows up as `req_ready` rising before 2*`cfg_trcd` cycles have passed, or never rising, right after the activation notice.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

    localparam int MAX_BEATS = 8;
    localparam int BEAT_W    = 3;
    localparam int SLOT_W    = 4;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } burst_ord_e;

    typedef struct packed {
        logic [SLOT_W-1:0] nbeats;
        burst_ord_e        ord;
        logic [BEAT_W-1:0] start_lo;
    } burst_cfg_t;

    function automatic logic [SLOT_W-1:0] beats_of(input logic [1:0] code);
        case (code)
            2'd2:    return 4'd4;
            2'd3:    return 4'd8;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] beat_offset(input burst_cfg_t c,
                                                      input logic [BEAT_W-1:0] idx);
        logic [BEAT_W-1:0] msk;
        logic [BEAT_W-1:0] s;
        msk = BEAT_W'(c.nbeats - 4'd1);
        s   = c.start_lo & msk;
        if (c.ord == ORD_INTLV) return (s ^ idx) & msk;
        else                    return BEAT_W'(s + idx) & msk;
    endfunction

endpackage

// File: rtl/ddr_wr_bank_gate.sv
module ddr_wr_bank_gate #(
    parameter int BA_W   = 2,
    parameter int TRCD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [BA_W-1:0]   act_bank,
    input  logic [TRCD_W-1:0] cfg_trcd,
    input  logic [BA_W-1:0]   bank_sel,
    output logic              bank_ok
);
    localparam int BANKS = 1 << BA_W;
    localparam int CNT_W = TRCD_W + 1;

    logic [BANKS-1:0] ok_vec;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_q;
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (act_valid && act_bank == BA_W'(b)) begin
                open_q <= 1'b1;
                cnt_q  <= '0;
            end else if (open_q && cnt_q != {CNT_W{1'b1}}) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end

        assign ok_vec[b] = open_q && (cnt_q >= {cfg_trcd, 1'b0});

        // R8: a bank just activated cannot be ready on the next cycle unless the delay is zero
        a_r8_fresh_act: assert property (@(posedge clk) disable iff (rst)
            (act_valid && act_bank == BA_W'(b) && cfg_trcd != '0) |=> !ok_vec[b]);
    end

    assign bank_ok = ok_vec[bank_sel];

endmodule

// File: rtl/ddr_wr_slot_seq.sv
module ddr_wr_slot_seq
    import ddr_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SLOT_W-1:0] nbeats,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    logic [SLOT_W-1:0] end_slot;

    assign end_slot = nbeats + 4'd3;
    assign last     = busy && (slot == end_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (start) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      slot <= slot + 1'b1;
        end
    end

    // R10: the final slot is followed by an idle cycle
    a_r10_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

endmodule

// File: rtl/ddr_wr_burst.sv
module ddr_wr_burst
    import ddr_wr_pkg::*;
#(
    parameter int DQ_W   = 32,
    parameter int COL_W  = 12,
    parameter int BA_W   = 2,
    parameter int TRCD_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                cfg_bl,
    input  logic                      cfg_bt,
    input  logic [TRCD_W-1:0]         cfg_trcd,
    input  logic                      act_valid,
    input  logic [BA_W-1:0]           act_bank,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BA_W-1:0]           req_bank,
    input  logic [COL_W-1:0]          req_col,
    input  logic [MAX_BEATS*DQ_W-1:0] req_data,
    input  logic [DQ_W-1:0]           req_mask,
    output logic                      mem_ck,
    output logic                      cmd_write,
    output logic [BA_W-1:0]           cmd_ba,
    output logic [COL_W-1:0]          cmd_addr,
    output logic                      dqs,
    output logic                      dqs_oe,
    output logic [DQ_W-1:0]           dq,
    output logic                      dq_oe,
    output logic [DQ_W/8-1:0]         dm,
    output logic                      dm_oe,
    output logic                      done
);
    localparam int DM_W = DQ_W / 8;

    logic              ph_q;
    logic              bank_ok;
    logic              accept;
    logic              busy;
    logic              last;
    logic [SLOT_W-1:0] slot;
    burst_cfg_t        cfg_q;
    logic [BA_W-1:0]   ba_q;
    logic [COL_W-1:0]  col_q;
    logic [DQ_W-1:0]   data_q [MAX_BEATS];
    logic [DM_W-1:0]   mask_q [MAX_BEATS];
    logic              in_data;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] off;

    // half-cycle phase: 0 = first half of a memory clock
    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end
    assign mem_ck = ~ph_q;

    ddr_wr_bank_gate #(.BA_W(BA_W), .TRCD_W(TRCD_W)) i_gate (
        .clk      (clk),
        .rst      (rst),
        .act_valid(act_valid),
        .act_bank (act_bank),
        .cfg_trcd (cfg_trcd),
        .bank_sel (req_bank),
        .bank_ok  (bank_ok)
    );

    assign req_ready = !busy && ph_q && bank_ok;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{nbeats: 4'd2, ord: ORD_SEQ, start_lo: '0};
            ba_q  <= '0;
            col_q <= '0;
        end else if (accept) begin
            cfg_q <= '{nbeats: beats_of(cfg_bl), ord: burst_ord_e'(cfg_bt),
                       start_lo: req_col[BEAT_W-1:0]};
            ba_q  <= req_bank;
            col_q <= req_col;
        end
    end

    for (genvar k = 0; k < MAX_BEATS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[k] <= '0;
                mask_q[k] <= '0;
            end else if (accept) begin
                data_q[k] <= req_data[k*DQ_W +: DQ_W];
                mask_q[k] <= req_mask[k*DM_W +: DM_W];
            end
        end
    end

    ddr_wr_slot_seq i_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .nbeats(cfg_q.nbeats),
        .busy  (busy),
        .slot  (slot),
        .last  (last)
    );

    assign cmd_write = busy && (slot < 4'd2);
    assign cmd_ba    = cmd_write ? ba_q  : '0;
    assign cmd_addr  = cmd_write ? col_q : '0;

    assign in_data = busy && (slot >= 4'd2) && (slot <= cfg_q.nbeats + 4'd1);
    assign beat    = BEAT_W'(slot - 4'd2);
    assign off     = beat_offset(cfg_q, beat);

    assign dqs_oe = busy && (slot <= cfg_q.nbeats + 4'd2);
    assign dqs    = in_data && !slot[0];
    assign dq_oe  = in_data;
    assign dm_oe  = in_data;
    assign dq     = in_data ? data_q[off] : '0;
    assign dm     = in_data ? mask_q[off] : '0;
    assign done   = last;

    // R1: an accepted request shows the command on the next cycle
    a_r1_cmd_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cmd_write && mem_ck));
    // R4: strobe rises only out of a driven low preamble
    a_r4_preamble: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs) |-> $past(dqs_oe));
    // R4: strobe is released only after a low postamble
    a_r4_postamble: assert property (@(posedge clk) disable iff (rst)
        $fell(dqs_oe) |-> !$past(dqs));
    // R3: data starts two cycles after the command began
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> ($past(cmd_write) && $past(cmd_write, 2)));
    // R5: data is only driven inside the strobe window
    a_r5_dq_in_window: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);
    // R10: done is a single pulse with the bus released
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |-> (!dqs_oe && !req_ready) ##1 !done);

endmodule

// File: tb/test_ddr_wr_burst.sv
module test_ddr_wr_burst;
    localparam int DQ_W = 32;
    localparam int COL_W = 12;
    localparam int BA_W = 2;
    localparam int TRCD_W = 4;
    localparam int DM_W = DQ_W / 8;

    // {bl code[16:15], order[14], bank[13:12], column[11:0]}
    localparam logic [16:0] VEC [8] = '{
        {2'd1, 1'b0, 2'd0, 12'h101},
        {2'd2, 1'b0, 2'd1, 12'h00E},
        {2'd3, 1'b0, 2'd2, 12'h0A5},
        {2'd3, 1'b1, 2'd0, 12'h3F3},
        {2'd2, 1'b1, 2'd1, 12'h007},
        {2'd1, 1'b1, 2'd2, 12'h001},
        {2'd0, 1'b0, 2'd0, 12'h004},
        {2'd3, 1'b1, 2'd1, 12'h006}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_bl = '0;
    logic cfg_bt = 1'b0;
    logic [TRCD_W-1:0] cfg_trcd = '0;
    logic act_valid = 1'b0;
    logic [BA_W-1:0] act_bank = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BA_W-1:0] req_bank = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [8*DQ_W-1:0] req_data = '0;
    logic [DQ_W-1:0] req_mask = '0;
    logic mem_ck, cmd_write, dqs, dqs_oe, dq_oe, dm_oe, done;
    logic [BA_W-1:0] cmd_ba;
    logic [COL_W-1:0] cmd_addr;
    logic [DQ_W-1:0] dq;
    logic [DM_W-1:0] dm;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    ddr_wr_burst #(.DQ_W(DQ_W), .COL_W(COL_W), .BA_W(BA_W), .TRCD_W(TRCD_W)) i_ddr_wr_burst (
        .clk(clk), .rst(rst), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt), .cfg_trcd(cfg_trcd),
        .act_valid(act_valid), .act_bank(act_bank), .req_valid(req_valid),
        .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col),
        .req_data(req_data), .req_mask(req_mask), .mem_ck(mem_ck),
        .cmd_write(cmd_write), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .dqs(dqs),
        .dqs_oe(dqs_oe), .dq(dq), .dq_oe(dq_oe), .dm(dm), .dm_oe(dm_oe), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] pat(input int v, input int k);
        return {8'(v), 8'(k), 16'hC35A ^ 16'(k * 257)};
    endfunction

    function automatic logic [DM_W-1:0] mpat(input int v, input int k);
        return DM_W'(v * 3 + k);
    endfunction

    task automatic activate(input logic [BA_W-1:0] b);
        @(negedge clk);
        act_valid = 1'b1;
        act_bank = b;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic run_burst(input int v);
        logic [1:0] code;
        int n;
        int s;
        int waitc;
        logic ord;
        logic [BA_W-1:0] bank;
        logic [COL_W-1:0] col;
        {code, ord, bank, col} = VEC[v];
        n = (code == 2'd2) ? 4 : (code == 2'd3) ? 8 : 2;
        s = int'(col) % n;
        @(negedge clk);
        cfg_bl = code;
        cfg_bt = ord;
        req_bank = bank;
        req_col = col;
        for (int k = 0; k < 8; k++) begin
            req_data[k*DQ_W +: DQ_W] = pat(v, k);
            req_mask[k*DM_W +: DM_W] = mpat(v, k);
        end
        req_valid = 1'b1;
        waitc = 0;
        while (!req_ready && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        chk("R9 mem_ck low when ready", 64'(mem_ck), 64'(0));
        @(negedge clk);
        // scramble inputs after acceptance: R2 captured at acceptance
        req_valid = 1'b0;
        cfg_bl = cfg_bl + 2'd1;
        cfg_bt = ~cfg_bt;
        req_col = ~req_col;
        req_bank = ~req_bank;
        req_data = ~req_data;
        req_mask = ~req_mask;
        for (int h = 0; h <= n + 3; h++) begin
            automatic bit ind = (h >= 2) && (h <= n + 1);
            automatic int off = ord ? (s ^ (h - 2)) : ((s + h - 2) % n);
            chk("R1 cmd_write", 64'(cmd_write), 64'(h < 2));
            chk("R1 cmd_ba", 64'(cmd_ba), (h < 2) ? 64'(bank) : 64'(0));
            chk("R1 cmd_addr", 64'(cmd_addr), (h < 2) ? 64'(col) : 64'(0));
            chk("R1 mem_ck", 64'(mem_ck), 64'(h % 2 == 0));
            chk("R4 dqs_oe", 64'(dqs_oe), 64'(h <= n + 2));
            chk("R4 dqs", 64'(dqs), 64'(ind && (h % 2 == 0)));
            chk("R3 R5 dq_oe", 64'(dq_oe), 64'(ind));
            chk("R5 dm_oe", 64'(dm_oe), 64'(ind));
            chk("R6 R2 dq", 64'(dq), ind ? 64'(pat(v, off)) : 64'(0));
            chk("R6 dm", 64'(dm), ind ? 64'(mpat(v, off)) : 64'(0));
            chk("R10 done", 64'(done), 64'(h == n + 3));
            if (h == n + 3) chk("R10 ready in done slot", 64'(req_ready), 64'(0));
            @(negedge clk);
        end
        chk("R7 idle enables", 64'({dqs_oe, dq_oe, dm_oe, dqs}), 64'(0));
        chk("R7 idle dq", 64'(dq), 64'(0));
        chk("R10 done single", 64'(done), 64'(0));
        @(negedge clk);
        req_bank = bank;
        #1;
        chk("R10 ready after done", 64'(req_ready), 64'(1));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first;
        bit early;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", 64'(req_ready), 64'(0));
        chk("R11 cmd_write", 64'(cmd_write), 64'(0));
        chk("R11 done", 64'(done), 64'(0));
        chk("R11 enables", 64'({dqs_oe, dq_oe, dm_oe}), 64'(0));
        // R8 a bank never activated is never ready
        req_bank = 2'd3;
        early = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready) early = 1;
        end
        chk("R8 unopened bank", 64'(early), 64'(0));
        // R8 delay window after activation
        cfg_trcd = 4'd5;
        req_bank = 2'd2;
        activate(2'd2);
        first = -1;
        for (int j = 1; j < 40; j++) begin
            if (req_ready && first < 0) first = j;
            @(negedge clk);
        end
        chk("R8 not before delay", 64'(first >= 10), 64'(1));
        chk("R8 ready soon after", 64'(first <= 11), 64'(1));
        // R9 ready only in the second half of a memory clock
        early = 0;
        for (int i = 0; i < 6; i++) begin
            if (req_ready && mem_ck) early = 1;
            @(negedge clk);
        end
        chk("R9 phase", 64'(early), 64'(0));
        cfg_trcd = 4'd2;
        activate(2'd0);
        activate(2'd1);
        repeat (8) @(negedge clk);
        for (int v = 0; v < 8; v++) run_burst(v);
        // R7 enables stay low while idle
        early = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dqs_oe || dq_oe || dm_oe || cmd_write) early = 1;
        end
        chk("R7 idle quiet", 64'(early), 64'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule